// File: doc/BRIEF.md
# Coded multicast delivery encoder

This block sits next to main memory and serves four cores whose private caches were filled in advance, each with one quarter of every application's data. Core k holds quarter k. The block replaces one reply per miss with one reply per pair of cores. For every pair of cores, each core already holds the quarter that the other core is missing. The block therefore reads both missing quarters, XORs them and broadcasts the result once. Each core recovers its own quarter by XORing the beat with the quarter it already holds.

A one-cycle `start` pulse captures the application index of each core. The block then visits all six core pairs. For each pair it issues two reads per beat on a synchronous memory read port and forms the coded beat. It offers that beat on a valid/ready broadcast stream, tagged with the pair's core mask. The broadcast follows ordinary stream rules. A beat is transferred on a clock edge where `bc_valid` and `bc_ready` are both high. Once a beat is offered, its data, mask and last flag stay unchanged until it is taken. The block never withdraws a beat. `bc_ready` may stay low for any length of time, and the block simply waits.

Top module: `coded_delivery_engine`

## Requirements
- R1: After reset, `busy`, `done`, `bc_valid` and `mem_rd_en` are low.
- R2: A `start` pulse while idle captures `req_app`, where core k's 2-bit application index sits in bits [2k+1:2k]. `busy` is high from the next cycle. Later changes on `req_app` have no effect on the delivery.
- R3: Every read uses the address {app[1:0], part[1:0], beat[BEAT_W-1:0]}. For pair (i,j) and beat b, the block reads {r_i, j, b} and {r_j, i, b}, where r_k is core k's captured index. Read data returns one cycle after `mem_rd_en`.
- R4: Each broadcast beat of pair (i,j) equals mem{r_i, j, b} XOR mem{r_j, i, b}. Different request sets therefore yield different chunks from the same walk.
- R5: Exactly six chunks are sent, each of BEATS beats in rising beat order. Pairs are visited in the order (0,1), (0,2), (0,3), (1,2), (1,3), (2,3). `bc_mask` has exactly bits i and j set, where bit k stands for core k. `bc_last` is high only on the final beat of a chunk.
- R6: While `bc_valid` is high and `bc_ready` is low, `bc_valid`, `bc_data`, `bc_mask` and `bc_last` hold their values.
- R7: `done` is high for exactly one cycle, in the cycle after the final beat of the sixth chunk is accepted. `busy` falls in that same cycle.
- R8: A `start` pulse during a delivery is ignored. The delivery in progress continues with its captured indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a delivery (honoured only while idle) |
| req_app | input | 8 | Application index per core, 2 bits each |
| busy | output | 1 | Delivery in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Read address {app, part, beat} |
| mem_rd_data | input | DATA_W | Read data, one cycle after request |
| bc_valid | output | 1 | Broadcast beat offered |
| bc_ready | input | 1 | Broadcast beat accepted |
| bc_data | output | DATA_W | Coded beat |
| bc_mask | output | 4 | Cores served by this chunk |
| bc_last | output | 1 | Final beat of the chunk |

## Verification
A corrupted pair counter or beat counter shows up on the next read address, only a few cycles later. It also shows up on the mask or last flag of the very next offered beat. A wrong captured index or a swapped partner quarter changes `bc_data` on the first beat of the affected pair. Both faults are caught by comparing every cycle against a queue of expected beats. A faulty handshake or end-of-walk decision shows up as a beat that changes during a stall. It can also show up as a missing, early or repeated `done`, in the cycle of the final transfer or the cycle after.

// File: rtl/cde_pkg.sv
package cde_pkg;
  localparam int NCORE  = 4;
  localparam int IDX_W  = 2;
  localparam int NPAIR  = NCORE * (NCORE - 1) / 2;
  localparam int PAIR_W = $clog2(NPAIR);

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_A,
    S_RD_B,
    S_MIX,
    S_SEND
  } seq_state_e;
endpackage

// File: rtl/cde_pair_map.sv
module cde_pair_map
  import cde_pkg::*;
(
  input  logic [PAIR_W-1:0] pair_idx,
  output logic [IDX_W-1:0]  core_lo,
  output logic [IDX_W-1:0]  core_hi,
  output logic [NCORE-1:0]  mask
);
  function automatic int lo_of(input int p);
    int n;
    n = 0;
    for (int a = 0; a < NCORE; a++)
      for (int b = a + 1; b < NCORE; b++) begin
        if (n == p) return a;
        n++;
      end
    return 0;
  endfunction

  function automatic int hi_of(input int p);
    int n;
    n = 0;
    for (int a = 0; a < NCORE; a++)
      for (int b = a + 1; b < NCORE; b++) begin
        if (n == p) return b;
        n++;
      end
    return 0;
  endfunction

  logic [IDX_W-1:0] lo_tab [NPAIR];
  logic [IDX_W-1:0] hi_tab [NPAIR];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign lo_tab[p] = IDX_W'(lo_of(p));
    assign hi_tab[p] = IDX_W'(hi_of(p));
  end

  always_comb begin
    core_lo = '0;
    core_hi = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (pair_idx == PAIR_W'(p)) begin
        core_lo = lo_tab[p];
        core_hi = hi_tab[p];
      end
    end
    mask = '0;
    mask[core_lo] = 1'b1;
    mask[core_hi] = 1'b1;
  end
endmodule

// File: rtl/cde_seq.sv
module cde_seq
  import cde_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NCORE*IDX_W-1:0]   req_app,
  input  logic                     bc_ready,
  input  logic [IDX_W-1:0]         core_lo,
  input  logic [IDX_W-1:0]         core_hi,
  output logic [PAIR_W-1:0]        pair_idx,
  output seq_state_e               state,
  output logic                     last_beat,
  output logic                     busy,
  output logic                     done,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr
);
  logic [NCORE*IDX_W-1:0] req_q;
  logic [BEAT_W-1:0]      beat_q;
  logic [IDX_W-1:0]       app_lo;
  logic [IDX_W-1:0]       app_hi;
  logic                   last_pair;

  assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
  assign last_pair = (pair_idx == PAIR_W'(NPAIR - 1));
  assign app_lo    = req_q[{core_lo, 1'b0} +: IDX_W];
  assign app_hi    = req_q[{core_hi, 1'b0} +: IDX_W];
  assign busy      = (state != S_IDLE);
  assign mem_rd_en = (state == S_RD_A) || (state == S_RD_B);

  always_comb begin
    if (state == S_RD_B) mem_rd_addr = {app_hi, core_lo, beat_q};
    else                 mem_rd_addr = {app_lo, core_hi, beat_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      req_q    <= '0;
      beat_q   <= '0;
      pair_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            req_q    <= req_app;
            beat_q   <= '0;
            pair_idx <= '0;
            state    <= S_RD_A;
          end
        end
        S_RD_A: state <= S_RD_B;
        S_RD_B: state <= S_MIX;
        S_MIX:  state <= S_SEND;
        S_SEND: begin
          if (bc_ready) begin
            if (last_beat) begin
              beat_q <= '0;
              if (last_pair) begin
                state <= S_IDLE;
                done  <= 1'b1;
              end else begin
                pair_idx <= pair_idx + 1'b1;
                state    <= S_RD_A;
              end
            end else begin
              beat_q <= beat_q + 1'b1;
              state  <= S_RD_A;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cde_mix.sv
module cde_mix #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first,
  input  logic              load_coded,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] coded
);
  localparam int NLANE = DATA_W / LANE_W;

  logic [DATA_W-1:0] first_q;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        first_q[l*LANE_W +: LANE_W] <= '0;
        coded[l*LANE_W +: LANE_W]   <= '0;
      end else begin
        if (load_first) first_q[l*LANE_W +: LANE_W] <= rd_data[l*LANE_W +: LANE_W];
        if (load_coded)
          coded[l*LANE_W +: LANE_W] <= first_q[l*LANE_W +: LANE_W] ^ rd_data[l*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/coded_delivery_engine.sv
module coded_delivery_engine
  import cde_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int ADDR_W = 2 * IDX_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        req_app,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              bc_valid,
  input  logic              bc_ready,
  output logic [DATA_W-1:0] bc_data,
  output logic [3:0]        bc_mask,
  output logic              bc_last
);
  logic [PAIR_W-1:0] pair_idx;
  logic [IDX_W-1:0]  core_lo;
  logic [IDX_W-1:0]  core_hi;
  logic [NCORE-1:0]  pair_mask;
  logic              last_beat;
  seq_state_e        state;

  cde_pair_map u_map (
    .pair_idx (pair_idx),
    .core_lo  (core_lo),
    .core_hi  (core_hi),
    .mask     (pair_mask)
  );

  cde_seq #(
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_app     (req_app),
    .bc_ready    (bc_ready),
    .core_lo     (core_lo),
    .core_hi     (core_hi),
    .pair_idx    (pair_idx),
    .state       (state),
    .last_beat   (last_beat),
    .busy        (busy),
    .done        (done),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
  );

  cde_mix #(
    .DATA_W (DATA_W)
  ) u_mix (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (state == S_RD_B),
    .load_coded (state == S_MIX),
    .rd_data    (mem_rd_data),
    .coded      (bc_data)
  );

  assign bc_valid = (state == S_SEND);
  assign bc_mask  = pair_mask;
  assign bc_last  = bc_valid && last_beat;
endmodule

// File: rtl/cde_checker.sv
module cde_checker #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              bc_valid,
  input logic              bc_ready,
  input logic [DATA_W-1:0] bc_data,
  input logic [3:0]        bc_mask,
  input logic              bc_last
);
  // R6: an offered beat holds while stalled
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && !bc_ready |=> bc_valid && $stable(bc_data) && $stable(bc_mask) && $stable(bc_last));

  // R5: every broadcast mask names exactly two cores
  p_mask_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> $countones(bc_mask) == 2);

  // R7: done is a single-cycle pulse following an accepted beat
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bc_valid && bc_ready && bc_last) && !busy);

  // R8: start while busy does not disturb the delivery
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(bc_valid && bc_ready && bc_last) |=> busy);

  // R3: reads only happen during a delivery, never while a beat is offered
  p_read_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy && !bc_valid);
endmodule

bind coded_delivery_engine cde_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .mem_rd_en (mem_rd_en),
  .bc_valid  (bc_valid),
  .bc_ready  (bc_ready),
  .bc_data   (bc_data),
  .bc_mask   (bc_mask),
  .bc_last   (bc_last)
);

// File: tb/tb_coded_delivery_engine.sv
module tb_coded_delivery_engine;
  localparam int DATA_W = 128;
  localparam int BEATS  = 4;
  localparam int BEAT_W = 2;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        req_app = '0;
  logic              busy, done, mem_rd_en, bc_valid, bc_last;
  logic              bc_ready = 1'b0;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic [DATA_W-1:0] bc_data;
  logic [3:0]        bc_mask;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  coded_delivery_engine #(.DATA_W(DATA_W), .BEATS(BEATS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_app(req_app),
    .busy(busy), .done(done), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .bc_valid(bc_valid), .bc_ready(bc_ready),
    .bc_data(bc_data), .bc_mask(bc_mask), .bc_last(bc_last)
  );

  function automatic logic [127:0] mem_val(input int app, input int part, input int beat);
    logic [31:0] w;
    w = 32'h1000_0000 + 32'(app) * 32'h0010_0000 + 32'(part) * 32'h100 + 32'(beat);
    return {w, w ^ 32'hFFFF_0000, 32'(w * 7), {w[15:0], w[31:16]}};
  endfunction

  // behavioural memory: registered read
  always @(posedge clk)
    if (mem_rd_en)
      mem_rd_data <= mem_val(int'(mem_rd_addr[5:4]), int'(mem_rd_addr[3:2]), int'(mem_rd_addr[1:0]));

  // ready generator, changes just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    case (ready_mode)
      0: bc_ready = 1'b1;
      1: bc_ready = lfsr[3];
      default: bc_ready = ((cyc % 9) == 8);
    endcase
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model
  logic [127:0]      q_data [$];
  logic [3:0]        q_mask [$];
  bit                q_last [$];
  logic [ADDR_W-1:0] q_ra [$];
  logic [ADDR_W-1:0] q_rb [$];
  bit model_busy = 0;
  bit fin_pending = 0;
  bit prev_stall = 0;

  task automatic build(input logic [7:0] r);
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        for (int b = 0; b < BEATS; b++) begin
          int ai, aj;
          ai = int'(r[2*i +: 2]);
          aj = int'(r[2*j +: 2]);
          q_data.push_back(mem_val(ai, j, b) ^ mem_val(aj, i, b));
          q_mask.push_back(4'((1 << i) | (1 << j)));
          q_last.push_back(b == BEATS - 1);
          q_ra.push_back({2'(ai), 2'(j), 2'(b)});
          q_rb.push_back({2'(aj), 2'(i), 2'(b)});
        end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == fin_pending, "R7 done", 128'(done), 128'(fin_pending));
      if (fin_pending) begin
        model_busy = 0;
        fin_pending = 0;
      end
      chk(busy == model_busy, "R2 busy", 128'(busy), 128'(model_busy));
      if (prev_stall)
        chk(bc_valid == 1'b1, "R6 valid held", 128'(bc_valid), 128'(1));
      if (start && !model_busy && q_data.size() == 0) begin
        build(req_app);
        model_busy = 1;
      end
      if (bc_valid) begin
        if (q_data.size() == 0) chk(1'b0, "R5 extra beat", 128'(1), 128'(0));
        else begin
          chk(bc_data == q_data[0], "R4 data", bc_data, q_data[0]);
          chk(bc_mask == q_mask[0], "R5 mask", 128'(bc_mask), 128'(q_mask[0]));
          chk(bc_last == q_last[0], "R5 last", 128'(bc_last), 128'(q_last[0]));
        end
      end
      if (mem_rd_en) begin
        if (q_ra.size() == 0) chk(1'b0, "R3 stray read", 128'(mem_rd_addr), 128'(0));
        else chk(mem_rd_addr == q_ra[0] || mem_rd_addr == q_rb[0], "R3 address",
                 128'(mem_rd_addr), 128'(q_ra[0]));
      end
      prev_stall = bc_valid && !bc_ready;
      if (bc_valid && bc_ready && q_data.size() != 0) begin
        void'(q_data.pop_front());
        void'(q_mask.pop_front());
        void'(q_last.pop_front());
        void'(q_ra.pop_front());
        void'(q_rb.pop_front());
        if (q_data.size() == 0) fin_pending = 1;
      end
    end
  end

  task automatic deliver(input logic [7:0] r, input int mode, input bit inject);
    int beats_seen;
    ready_mode = mode;
    @(posedge clk); #1;
    start = 1'b1;
    req_app = r;
    @(posedge clk); #1;
    start = 1'b0;
    req_app = ~r;  // R2: later changes must not matter
    if (inject) begin
      repeat (7) @(posedge clk);
      #1;
      start = 1'b1;  // R8: ignored while busy
      req_app = r ^ 8'h5A;
      @(posedge clk); #1;
      start = 1'b0;
    end
    repeat (2) @(negedge clk);
    beats_seen = 0;
    while (model_busy || q_data.size() != 0) begin
      @(negedge clk);
      beats_seen++;
    end
    chk(q_data.size() == 0, "R5 all beats sent", 128'(q_data.size()), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!busy, "R1 busy", 128'(busy), 128'(0));
    chk(!done, "R1 done", 128'(done), 128'(0));
    chk(!bc_valid, "R1 valid", 128'(bc_valid), 128'(0));
    chk(!mem_rd_en, "R1 rd_en", 128'(mem_rd_en), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    deliver(8'b11_10_01_00, 0, 0);  // R4 apps 0,1,2,3 on cores 0..3
    deliver(8'b01_00_11_10, 1, 0);  // R4 rotated request set, random stalls
    deliver(8'b11_11_11_11, 2, 0);  // R6 same app everywhere, long stalls
    deliver(8'b10_11_00_01, 1, 1);  // R8 start during delivery
    deliver(8'b00_00_01_01, 0, 0);  // R7 back-to-back run
    repeat (4) @(negedge clk);
    chk(!busy && !bc_valid, "R7 idle at end", 128'(busy), 128'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule